// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the digital behaviour of a 1 Kbit serial nonvolatile memory that is driven over a three-wire select/clock/data link. A host raises chip select and clocks in a start bit, a two-bit opcode, an address and, for store operations, a data word. The array is 1024 bits. It is seen either as 64 sixteen-bit words or as 128 bytes, chosen by an organization input. That input also sets the address length (6 or 7 bits) and the data length (16 or 8 bits).

The serial clock is oversampled by a faster system clock. Chip select, serial clock and serial data pass through two-flop synchronizers, and the block acts on the rising and falling edges of the synchronized serial clock. Read data comes out on a data-out pin that has its own output-enable. Store and erase operations are gated by a write-enable latch that is clear after reset. Each one starts a self-timed cycle when chip select falls. The length of that cycle is a parameter counted in system-clock cycles, and the data-out pin reports busy or ready while it runs.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, `do_oe` is low and stores are disabled. A WRITE sent before any enable instruction leaves the addressed word unchanged.
- R2: With `org`=1 the array is 64 sixteen-bit words with 6-bit addresses. With `org`=0 it is 128 bytes with 7-bit addresses. Word n in the 16-bit view is byte 2n (upper half) followed by byte 2n+1 (lower half).
- R3: An instruction starts at the first serial-clock rising edge that sees data-in=1 while chip select is high; earlier zeros are skipped. A READ (opcode 10) drives one 0 bit and then the word, most significant bit first. The 0 bit follows the rising edge that takes in the last address bit, and each data bit follows one further rising edge.
- R4: While clocking continues, a READ moves on to the next address. It wraps from the top address to address 0.
- R5: A WRITE (opcode 01) followed by a full data word stores exactly that word once chip select falls and the program cycle ends.
- R6: An ERASE (opcode 11) sets the addressed word to all ones.
- R7: With opcode 00, the two most significant address bits select the function: 11 enables stores, 00 disables them, 10 sets the whole array to ones, and 01 writes the data word that follows to every word.
- R8: ERASE, WRITE, erase-all and write-all have no effect while stores are disabled, including after a disable instruction.
- R9: When chip select falls at the end of an accepted store or erase instruction, the busy cycle starts and lasts `CYC_PROG` system clocks. While chip select is high, `do_oe` is high and `do_o` is 0 during busy and 1 once ready.
- R10: A 1 clocked in on data-in while status is shown keeps `do_oe` high until the next serial-clock falling edge, and `do_oe` goes low after that edge.
- R11: `do_oe` is low while chip select is low.
- R12: If chip select falls before the last data bit of a WRITE arrives, the instruction is dropped and memory does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in, sampled on the rising edge of `sk` |
| org | input | 1 | Organization: 1 selects 16-bit words, 0 selects bytes |
| do_o | output | 1 | Serial data out: read data or ready/busy status |
| do_oe | output | 1 | Output-enable for `do_o`; low means high impedance |

## Verification
The bench builds the block with `CYC_PROG`=60. This keeps a whole busy window, from launch to ready, within a few serial bit times. As a result, the busy level of the status bit, its change to ready, and the release of data-out after a dummy 1 can all be checked inside one chip-select period. The bench also runs enough store, erase and sequential-read traffic in both organizations to cover the upper-address wrap in each view and the byte-to-word overlap between the two views.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int CYC_PROG = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic do_o,
  output logic do_oe
);
  localparam int CW = $clog2(CYC_PROG + 1);
  localparam logic [1:0] K_WR = 2'd0, K_ER = 2'd1, K_ERAL = 2'd2, K_WRAL = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_RD, S_WD, S_DONE} st_t;

  logic [1:0] cs_m, sk_m, di_m;
  logic sk_d;
  wire cs_s = cs_m[1];
  wire sk_s = sk_m[1];
  wire di_s = di_m[1];
  wire sk_rise = cs_s & sk_s & ~sk_d;
  wire sk_fall = ~sk_s & sk_d;

  st_t st;
  logic [8:0] sr;
  logic [4:0] bcnt;
  logic [6:0] a_q;
  logic [15:0] wd, rd_sr;
  logic [4:0] rd_cnt;
  logic do_q, wen, pend, p_x16, busy, stat, rel;
  logic [1:0] pk;
  logic [CW-1:0] cnt;
  logic [7:0] mem [128];

  wire [8:0] nsr = {sr[7:0], di_s};
  wire [4:0] hdr_last = org ? 5'd7 : 5'd8;
  wire [4:0] dw_last = org ? 5'd15 : 5'd7;
  wire [1:0] op = org ? nsr[7:6] : nsr[8:7];
  wire [1:0] sub = org ? nsr[5:4] : nsr[6:5];
  wire [6:0] addr = org ? {1'b0, nsr[5:0]} : nsr[6:0];
  wire [6:0] a_nx = org ? {1'b0, a_q[5:0] + 6'd1} : a_q + 7'd1;
  wire prog_end = busy && cnt == CW'(1);

  function automatic logic [15:0] word_at(input logic [6:0] a, input logic x16);
    return x16 ? {mem[{a[5:0], 1'b0}], mem[{a[5:0], 1'b1}]} : {mem[a], 8'h00};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_m <= '0; sk_m <= '0; di_m <= '0; sk_d <= 1'b0;
      st <= S_IDLE; sr <= '0; bcnt <= '0; a_q <= '0; wd <= '0;
      rd_sr <= '0; rd_cnt <= '0; do_q <= 1'b0; wen <= 1'b0; pend <= 1'b0;
      p_x16 <= 1'b0; pk <= K_WR; busy <= 1'b0; cnt <= '0; stat <= 1'b0; rel <= 1'b0;
    end else begin
      cs_m <= {cs_m[0], cs};
      sk_m <= {sk_m[0], sk};
      di_m <= {di_m[0], di};
      sk_d <= sk_s;

      if (busy) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) busy <= 1'b0;
      end

      if (!cs_s) begin
        st <= S_IDLE;
        bcnt <= '0;
      end else if (sk_rise && !busy) begin
        case (st)
          S_IDLE: if (di_s) begin st <= S_HDR; bcnt <= '0; sr <= '0; end
          S_HDR: begin
            sr <= nsr;
            bcnt <= bcnt + 5'd1;
            if (bcnt == hdr_last) begin
              a_q <= addr;
              bcnt <= '0;
              p_x16 <= org;
              st <= S_DONE;
              case (op)
                2'b10: begin
                  st <= S_RD; rd_sr <= word_at(addr, org); rd_cnt <= '0; do_q <= 1'b0;
                end
                2'b01: begin st <= S_WD; pk <= K_WR; end
                2'b11: begin pk <= K_ER; pend <= wen; end
                default: case (sub)
                  2'b11: wen <= 1'b1;
                  2'b00: wen <= 1'b0;
                  2'b10: begin pk <= K_ERAL; pend <= wen; end
                  default: begin st <= S_WD; pk <= K_WRAL; end
                endcase
              endcase
            end
          end
          S_WD: begin
            wd <= {wd[14:0], di_s};
            bcnt <= bcnt + 5'd1;
            if (bcnt == dw_last) begin st <= S_DONE; pend <= wen; end
          end
          S_RD: begin
            do_q <= rd_sr[15];
            if (rd_cnt == dw_last) begin
              a_q <= a_nx; rd_sr <= word_at(a_nx, org); rd_cnt <= '0;
            end else begin
              rd_sr <= {rd_sr[14:0], 1'b0}; rd_cnt <= rd_cnt + 5'd1;
            end
          end
          default: ;
        endcase
      end

      if (sk_rise && stat && di_s) rel <= 1'b1;
      if (sk_fall && rel) begin stat <= 1'b0; rel <= 1'b0; end

      if (!cs_s && pend) begin
        busy <= 1'b1; cnt <= CW'(CYC_PROG); pend <= 1'b0; stat <= 1'b1; rel <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (prog_end) begin
      case (pk)
        K_WR: if (p_x16) begin
          mem[{a_q[5:0], 1'b0}] <= wd[15:8];
          mem[{a_q[5:0], 1'b1}] <= wd[7:0];
        end else mem[a_q] <= wd[7:0];
        K_ER: if (p_x16) begin
          mem[{a_q[5:0], 1'b0}] <= 8'hFF;
          mem[{a_q[5:0], 1'b1}] <= 8'hFF;
        end else mem[a_q] <= 8'hFF;
        K_ERAL: for (int i = 0; i < 128; i++) mem[i] <= 8'hFF;
        default: for (int i = 0; i < 128; i++)
          mem[i] <= (p_x16 && i[0] == 1'b0) ? wd[15:8] : wd[7:0];
      endcase
    end
  end

  assign do_oe = cs_s & (stat | st == S_RD);
  assign do_o = stat ? ~busy : do_q;

  // R9
  launch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pend) && !$past(cs_s));
  // R9
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> cnt < $past(cnt));
  // R9
  parser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> st == S_IDLE);
  // R8
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(wen));
  // R10
  release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat) |-> $past(sk_fall));
  // R11
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cs_s) |-> st == S_IDLE);
endmodule

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
  localparam int CYC = 60;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_o, do_oe;
  int errs = 0, checks = 0;
  bit done = 1'b0;
  logic [7:0] ref_m [128];
  bit ref_wen = 1'b0;

  mw_eeprom #(.CYC_PROG(CYC)) dut (.clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .org(org), .do_o(do_o), .do_oe(do_oe));

  always #10 clk = ~clk;

  task automatic chk(input string r, input logic [15:0] a, input logic [15:0] e);
    checks++;
    if (a !== e) begin
      errs++;
      $display("FAIL %s: got %h expected %h", r, a, e);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input bit b, output logic o, output logic oe);
    di = b; tick(4);
    o = do_o; oe = do_oe;
    sk = 1'b1; tick(4); sk = 1'b0;
  endtask

  task automatic csel();
    sk = 1'b0; cs = 1'b1; tick(3);
  endtask

  task automatic cdesel();
    sk = 1'b0; cs = 1'b0; di = 1'b0; tick(5);
  endtask

  function automatic int aw();
    return org ? 6 : 7;
  endfunction

  function automatic int dw();
    return org ? 16 : 8;
  endfunction

  function automatic logic [15:0] word_ref(input logic [6:0] a);
    return org ? {ref_m[{a[5:0], 1'b0}], ref_m[{a[5:0], 1'b1}]} : {8'h00, ref_m[a]};
  endfunction

  task automatic hdr(input logic [1:0] op, input logic [6:0] a);
    logic o, oe;
    sbit(1'b1, o, oe);
    sbit(op[1], o, oe); sbit(op[0], o, oe);
    for (int i = aw() - 1; i >= 0; i--) sbit(a[i], o, oe);
  endtask

  task automatic dat(input logic [15:0] d);
    logic o, oe;
    for (int i = dw() - 1; i >= 0; i--) sbit(d[i], o, oe);
  endtask

  task automatic special(input logic [1:0] code, input bit with_data, input logic [15:0] d);
    csel();
    hdr(2'b00, org ? {1'b0, code, 4'b0} : {code, 5'b0});
    if (with_data) dat(d);
    cdesel();
    tick(CYC + 10);
  endtask

  task automatic ewen(); special(2'b11, 0, 0); ref_wen = 1'b1; endtask
  task automatic ewds(); special(2'b00, 0, 0); ref_wen = 1'b0; endtask

  task automatic eral();
    special(2'b10, 0, 0);
    if (ref_wen) for (int i = 0; i < 128; i++) ref_m[i] = 8'hFF;
  endtask

  task automatic wral(input logic [15:0] d);
    special(2'b01, 1, d);
    if (ref_wen) for (int i = 0; i < 128; i++)
      ref_m[i] = (org && i[0] == 1'b0) ? d[15:8] : d[7:0];
  endtask

  task automatic put_ref(input logic [6:0] a, input logic [15:0] d);
    if (org) begin ref_m[{a[5:0], 1'b0}] = d[15:8]; ref_m[{a[5:0], 1'b1}] = d[7:0]; end
    else ref_m[a] = d[7:0];
  endtask

  task automatic write_op(input logic [6:0] a, input logic [15:0] d);
    csel(); hdr(2'b01, a); dat(d); cdesel();
    if (ref_wen) put_ref(a, d);
    tick(CYC + 10);
  endtask

  task automatic erase_op(input logic [6:0] a);
    csel(); hdr(2'b11, a); cdesel();
    if (ref_wen) put_ref(a, 16'hFFFF);
    tick(CYC + 10);
  endtask

  task automatic read_words(input logic [6:0] a, input int n, input string r, input bit cmp,
                            output logic [15:0] first);
    logic o, oe;
    logic [15:0] w;
    logic [6:0] ad = a;
    csel(); hdr(2'b10, a);
    sbit(1'b0, o, oe);
    chk("R3 dummy bit", {14'b0, oe, o}, 16'b10);
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int i = 0; i < dw(); i++) begin
        sbit(1'b0, o, oe);
        w = {w[14:0], o};
      end
      if (k == 0) first = w;
      if (cmp) chk(r, w, word_ref(ad));
      ad = org ? {1'b0, ad[5:0] + 6'd1} : ad + 7'd1;
    end
    cdesel();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v0, v1;
    logic o, oe;
    void'($urandom(32'h5EED_0042));
    tick(5); rst_n = 1'b1; tick(3);
    chk("R1 reset oe", {15'b0, do_oe}, 16'h0);

    org = 1'b1;
    read_words(7'd5, 1, "R1", 0, v0);
    write_op(7'd5, 16'h1234);
    read_words(7'd5, 1, "R1", 0, v1);
    chk("R1 write before enable", v1, v0);

    ewen(); eral();
    read_words(7'd0, 1, "R7 erase all", 1, v0);
    wral(16'hA5C3);
    read_words(7'd10, 2, "R7 write all", 1, v0);

    org = 1'b0;
    read_words(7'd20, 2, "R2 byte view", 1, v0);
    write_op(7'd127, 16'h003C);
    read_words(7'd127, 2, "R4 x8 wrap", 1, v0);

    org = 1'b1;
    write_op(7'd63, 16'hBEEF);
    read_words(7'd63, 2, "R4 x16 wrap", 1, v0);
    write_op(7'd2, 16'h0F1E);
    read_words(7'd2, 1, "R5 write word", 1, v0);
    org = 1'b0;
    read_words(7'd4, 2, "R2 word halves", 1, v0);
    org = 1'b1;
    erase_op(7'd3);
    read_words(7'd3, 1, "R6 erase word", 1, v0);

    ewds();
    write_op(7'd4, 16'h0000);
    erase_op(7'd2);
    read_words(7'd2, 3, "R8 disabled", 1, v0);
    ewen();

    csel(); hdr(2'b01, 7'd9); dat(16'h4242);
    cs = 1'b0; tick(3); cs = 1'b1; tick(5);
    chk("R9 busy status", {14'b0, do_oe, do_o}, 16'b10);
    tick(CYC);
    chk("R9 ready status", {14'b0, do_oe, do_o}, 16'b11);
    put_ref(7'd9, 16'h4242);
    di = 1'b1; tick(4); sk = 1'b1; tick(4);
    chk("R10 held before fall", {15'b0, do_oe}, 16'h1);
    sk = 1'b0; tick(4);
    chk("R10 released after fall", {15'b0, do_oe}, 16'h0);
    cdesel();
    chk("R11 deselected", {15'b0, do_oe}, 16'h0);
    read_words(7'd9, 1, "R5 status write", 1, v0);

    csel(); hdr(2'b01, 7'd9);
    for (int i = 0; i < 5; i++) sbit(1'b0, o, oe);
    cdesel(); tick(CYC + 10);
    chk("R11 after abort", {15'b0, do_oe}, 16'h0);
    read_words(7'd9, 1, "R12 aborted write", 1, v0);

    for (int it = 0; it < 40; it++) begin
      logic [6:0] a;
      org = $urandom % 2;
      a = org ? {1'b0, 6'($urandom)} : 7'($urandom);
      case ($urandom % 3)
        0: write_op(a, 16'($urandom));
        1: erase_op(a);
        default: ;
      endcase
      read_words(a, 2, "R5 random", 1, v0);
    end
    finish_run();
  end
endmodule